// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple word-oriented host port and a two-bank array of extended-data-out DRAM. It takes 32-bit read and write requests through a valid/ready handshake. It then produces the row strobes, the per-byte column strobes, the write-enable strobe and the time-shared 10-bit address bus that the memory expects. Every delay is counted in system clock cycles and is set by a parameter.

A request address of 21 bits selects one of two banks, a row and a column. After the first access to a row, the row stays open. Later requests to the same bank and row are served with column-only (hyper-page) cycles. A request to a different row closes the open row first. A request from the separate refresh scheduler also closes the row. Writes are always early writes: the write strobe and the data are on the pins before any column strobe falls. The column strobes act as byte enables. For reads, the data is captured at the end of the column strobe pulse and returned with a one-cycle valid pulse.

Top module: `edo_ctrl`

## Requirements
- R1: Request address bit 20 selects the bank, bits 19:10 are the row and bits 9:0 are the column. The row is on `dram_addr` when the row strobe falls. The column is on `dram_addr` when a column strobe falls. The address stays stable while any column strobe is low.
- R2: Bank 0 drives `dram_ras_n` = 4'b1100 (bits 1:0 low). Bank 1 drives 4'b0011 (bits 3:2 low). No other value with any bit low ever appears.
- R3: In a write, `dram_we_n` is low, `dram_dq_oe` is high and `dram_dq_o` carries the write data in the cycle before the column strobes fall. All three hold while the strobes are low.
- R4: Column strobe bit i covers data bits 8i+7:8i. A write pulls low only the bits whose `req_be` bit is 1, so that `dram_cas_n` = ~`req_be`. A read pulls all four low.
- R5: The first column strobe of a row falls exactly T_RCD cycles after the row strobe falls. Every column strobe pulse lasts T_CAS cycles. Column strobes are low only while a row strobe is low.
- R6: Read data is sampled from `dram_dq_i` on the edge where the column strobes rise, which is T_CAS cycles after they fall. It is presented on `rsp_rdata`, and `rsp_valid` is high for exactly one cycle.
- R7: A request to the bank and row that are already open is served without any new row strobe transition.
- R8: A request to a different row or bank closes the open row. The row strobes then stay high for exactly T_RP cycles before the new row opens, and the new access completes with the correct data.
- R9: A row strobe stays low for at least T_RAS cycles and for at most T_RAS_MAX cycles. With no requests pending, an open row closes after T_RAS_MAX - T_CP - T_CAS - 1 cycles.
- R10: While `ref_req` is high, no new host request is accepted and the open row closes at the next access boundary. After precharge, `ref_gnt` is held high until `ref_req` falls. While `ref_gnt` is high, all row and column strobes are high and the data pins are not driven.
- R11: After reset, all strobes are high, `dram_dq_oe` is 0, and `rsp_valid` and `ref_gnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 21 | Word address: bank, row, column |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 32 | Read data |
| ref_req | input | 1 | Refresh scheduler wants the memory |
| ref_gnt | output | 1 | Memory handed to the refresh scheduler |
| dram_ras_n | output | 4 | Row strobes, a pair per bank, active low |
| dram_cas_n | output | 4 | Per-byte column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 32 | Data driven to memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_i | input | 32 | Data returned from memory |

## Verification
The bench builds the controller with T_RP=3, T_RCD=3, T_CAS=2 and T_CP=1, matching the fast grade at a 10 ns clock. It raises T_RAS to 8, so that a miss issued right after a first access has to wait out the minimum row-low time. It lowers T_RAS_MAX to 20, so the forced close of an idle row happens within a few dozen cycles and its exact length of 16 cycles can be checked. A behavioural memory model stores the byte lanes under each column strobe and returns data while the strobes are low. This lets merged byte writes, page hits, bank misses and the refresh hand-over be checked against values computed from the requirements.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RAS     = 5,
  parameter int T_RAS_MAX = 1000,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DW        = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ROW_W+COL_W:0]       req_addr,
  input  logic                       req_we,
  input  logic [DW-1:0]              req_wdata,
  input  logic [DW/8-1:0]            req_be,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_rdata,
  input  logic                       ref_req,
  output logic                       ref_gnt,
  output logic [3:0]                 dram_ras_n,
  output logic [DW/8-1:0]            dram_cas_n,
  output logic                       dram_we_n,
  output logic [ROW_W-1:0]           dram_addr,
  output logic [DW-1:0]              dram_dq_o,
  output logic                       dram_dq_oe,
  input  logic [DW-1:0]              dram_dq_i
);
  localparam int AW       = ROW_W + COL_W + 1;
  localparam int NB       = DW / 8;
  localparam int CLOSE_AT = T_RAS_MAX - T_CP - T_CAS - 1;
  localparam int CW       = $clog2(T_RP + T_RCD + T_CAS + T_CP + 1) + 1;
  localparam int RW       = $clog2(T_RAS_MAX + 2) + 1;

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_COL, S_CAS, S_OPEN, S_REF} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    ras_cnt;
  logic             o_bank;
  logic [ROW_W-1:0] o_row;
  logic [COL_W-1:0] c_col;
  logic             c_we;
  logic [NB-1:0]    c_be;

  wire              r_bank  = req_addr[AW-1];
  wire [ROW_W-1:0]  r_row   = req_addr[AW-2 -: ROW_W];
  wire [COL_W-1:0]  r_col   = req_addr[COL_W-1:0];
  wire              hit     = (st == S_OPEN) && (r_bank == o_bank) && (r_row == o_row);
  wire              ras_ok  = ras_cnt >= RW'(T_RAS);
  wire              timeout = ras_cnt >= RW'(CLOSE_AT);
  wire              idle_go = (st == S_IDLE) && (cnt == '0) && !ref_req;
  wire              page_go = hit && !ref_req && !timeout;
  wire              close   = (st == S_OPEN) && ras_ok &&
                              (ref_req || timeout || (req_valid && !hit));
  wire [NB-1:0]     cas_pat = c_we ? ~c_be : '0;

  assign req_ready = idle_go || page_go;
  assign ref_gnt   = (st == S_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ras_cnt <= '0;
      o_bank <= 1'b0;
      o_row <= '0;
      c_col <= '0;
      c_we <= 1'b0;
      c_be <= '0;
      dram_ras_n <= '1;
      dram_cas_n <= '1;
      dram_we_n <= 1'b1;
      dram_addr <= '0;
      dram_dq_o <= '0;
      dram_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ras_cnt <= (dram_ras_n == '1) ? '0 : ras_cnt + 1'b1;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (cnt == '0) begin
          if (ref_req) st <= S_REF;
          else if (req_valid) begin
            dram_ras_n <= r_bank ? 4'b0011 : 4'b1100;
            dram_addr <= r_row;
            ras_cnt <= RW'(1);
            o_bank <= r_bank;
            o_row <= r_row;
            c_col <= r_col;
            c_we <= req_we;
            c_be <= req_be;
            dram_we_n <= !req_we;
            dram_dq_oe <= req_we;
            dram_dq_o <= req_wdata;
            cnt <= CW'(T_RCD - 1);
            st <= S_RCD;
          end
        end
        S_RCD: begin
          dram_addr <= c_col;
          if (cnt == '0) begin
            dram_cas_n <= cas_pat;
            cnt <= CW'(T_CAS - 1);
            st <= S_CAS;
          end
        end
        S_COL: if (cnt == '0) begin
          dram_cas_n <= cas_pat;
          cnt <= CW'(T_CAS - 1);
          st <= S_CAS;
        end
        S_CAS: if (cnt == '0) begin
          dram_cas_n <= '1;
          dram_we_n <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!c_we) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dq_i;
          end
          st <= S_OPEN;
        end
        S_OPEN: begin
          if (close) begin
            dram_ras_n <= '1;
            ras_cnt <= '0;
            cnt <= CW'(T_RP - 1);
            st <= S_IDLE;
          end else if (req_valid && page_go) begin
            dram_addr <= r_col;
            c_we <= req_we;
            c_be <= req_be;
            dram_we_n <= !req_we;
            dram_dq_oe <= req_we;
            dram_dq_o <= req_wdata;
            cnt <= CW'(T_CP - 1);
            st <= S_COL;
          end
        end
        S_REF: if (!ref_req) begin
          cnt <= CW'(T_RP - 1);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 1000,
  parameter int ROW_W     = 10,
  parameter int NB        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ras_n,
  input logic [NB-1:0]    cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic [ROW_W-1:0] addr,
  input logic             rsp_valid,
  input logic             ref_gnt
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'(T_RP);
    end else if (ras_n != '1) begin
      lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == 4'hF) || (ras_n == 4'hC) || (ras_n == 4'h3)); // R2
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1 && $past(cas_n) == '1 && !we_n) |-> ($past(!we_n) && $past(dq_oe))); // R3
  AST_CAS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1 && $past(cas_n) != '1) |-> ($stable(addr) && $stable(we_n) && $stable(cas_n))); // R1
  AST_READ_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1 && we_n) |-> (cas_n == '0)); // R4
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> (ras_n != '1)); // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1 && $past(ras_n) == '1) |-> (hi_cnt >= 16'(T_RP))); // R8
  AST_RAS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1) |-> (lo_cnt < 16'(T_RAS_MAX))); // R9
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n == '1 && cas_n == '1 && !dq_oe)); // R10
endmodule

bind edo_ctrl edo_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX), .ROW_W(ROW_W), .NB(DW/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .dq_oe(dram_dq_oe), .addr(dram_addr), .rsp_valid(rsp_valid), .ref_gnt(ref_gnt));

// File: tb/sim_edo_ctrl.sv
module sim_edo_ctrl;
  localparam int CLK_NS = 10;
  localparam int P_RP = 3, P_RCD = 3, P_CAS = 2, P_CP = 1, P_RAS = 8, P_RMAX = 20;
  localparam int P_CLOSE = P_RMAX - P_CP - P_CAS - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_req = 0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, rsp_valid, ref_gnt, dram_we_n, dram_dq_oe;
  logic [31:0] rsp_rdata, dram_dq_o, dram_dq_i;
  logic [3:0] dram_ras_n, dram_cas_n;
  logic [9:0] dram_addr;

  edo_ctrl #(.T_RP(P_RP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP), .T_RAS(P_RAS),
             .T_RAS_MAX(P_RMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic acc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    acc <= req_valid && req_ready;
  end

  function automatic logic [31:0] init_val(input logic [7:0] i);
    return {16'h5A5A, i, ~i};
  endfunction
  function automatic logic [20:0] mk(input logic b, input int r, input int c);
    return {b, 10'(r), 10'(c)};
  endfunction

  logic [31:0] mem [256];
  logic [7:0] rd_idx = '0;
  logic [3:0] prev_ras = 4'hF, prev_cas = 4'hF, last_ras_pat = 4'hF, last_cas_pat = 4'hF;
  logic prev_we = 1, we_at_fall = 1, m_bank = 0;
  logic [9:0] m_row = '0, last_col = '0;
  logic [31:0] dq_at_fall = '0, rsp_data = '0;
  int ras_fall_cyc = 0, ras_rise_cyc = 0, cas_fall_cyc = 0, rsp_cyc = 0;
  int ras_falls = 0, cas_falls = 0, rsp_cnt = 0, low_len = 0, high_len = 0, quiet_bad = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
  assign dram_dq_i = mem[rd_idx];

  always @(negedge clk) begin
    if (prev_ras == 4'hF && dram_ras_n != 4'hF) begin
      ras_fall_cyc = cyc; ras_falls++; last_ras_pat = dram_ras_n;
      m_row = dram_addr; m_bank = (dram_ras_n == 4'b0011);
      high_len = cyc - ras_rise_cyc;
    end
    if (prev_ras != 4'hF && dram_ras_n == 4'hF) begin
      ras_rise_cyc = cyc; low_len = cyc - ras_fall_cyc;
    end
    if (prev_cas == 4'hF && dram_cas_n != 4'hF) begin
      cas_fall_cyc = cyc; cas_falls++; last_cas_pat = dram_cas_n;
      last_col = dram_addr; we_at_fall = prev_we; dq_at_fall = dram_dq_o;
      rd_idx = {m_bank, m_row[2:0], dram_addr[3:0]};
      if (!dram_we_n)
        for (int b = 0; b < 4; b++)
          if (!dram_cas_n[b]) mem[rd_idx][8*b +: 8] = dram_dq_o[8*b +: 8];
    end
    if (rsp_valid) begin rsp_cyc = cyc; rsp_cnt++; rsp_data = rsp_rdata; end
    if (ref_gnt && (dram_ras_n != 4'hF || dram_cas_n != 4'hF || dram_dq_oe)) quiet_bad++;
    prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [20:0] a, input logic w, input logic [31:0] d, input logic [3:0] be);
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = w; req_wdata = d; req_be = be;
    do begin @(negedge clk); n++; end while (!acc && n < 200);
    req_valid = 0;
    if (!acc) chk("handshake", 0, 1);
  endtask

  task automatic read_word(input logic [20:0] a, output logic [31:0] d);
    int rc = rsp_cnt, n = 0;
    issue(a, 0, 0, 4'h0);
    while (rsp_cnt == rc && n < 50) begin @(negedge clk); n++; end
    d = rsp_data;
  endtask

  task automatic write_word(input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
    int cc = cas_falls, n = 0;
    issue(a, 1, d, be);
    while (cas_falls == cc && n < 50) begin @(negedge clk); n++; end
    repeat (P_CAS + 1) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 reset pins", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, rsp_valid, ref_gnt},
        {4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0});
  endtask

  task automatic t_write_read;
    logic [31:0] d; int rf;
    write_word(mk(0, 5, 3), 32'hDEADBEEF, 4'hF);
    chk("R2 bank0 ras pair", last_ras_pat, 4'b1100);
    chk("R1 row at ras fall", m_row, 5);
    chk("R1 col at cas fall", last_col, 3);
    chk("R3 we low before cas", we_at_fall, 0);
    chk("R3 data at cas fall", dq_at_fall, 32'hDEADBEEF);
    chk("R5 ras to cas delay", cas_fall_cyc - ras_fall_cyc, P_RCD);
    chk("R4 full write lanes", last_cas_pat, 4'b0000);
    rf = ras_falls;
    read_word(mk(0, 5, 3), d);
    chk("R6 read data", d, 32'hDEADBEEF);
    chk("R6 sample latency", rsp_cyc - cas_fall_cyc, P_CAS);
    chk("R7 page hit no ras", ras_falls, rf);
  endtask

  task automatic t_byte;
    logic [31:0] d;
    write_word(mk(0, 5, 4), 32'h11223344, 4'hF);
    write_word(mk(0, 5, 4), 32'hAABBCCDD, 4'b0101);
    chk("R4 byte lane strobes", last_cas_pat, 4'b1010);
    read_word(mk(0, 5, 4), d);
    chk("R4 merged bytes", d, 32'h11BB33DD);
    chk("R4 read lanes", last_cas_pat, 4'b0000);
  endtask

  task automatic t_miss;
    logic [31:0] d;
    repeat (40) @(negedge clk);
    read_word(mk(0, 6, 1), d);
    chk("R8 first row data", d, init_val(8'h61));
    read_word(mk(1, 2, 7), d);
    chk("R9 min row low", 32'(low_len >= P_RAS), 1);
    chk("R8 precharge length", high_len, P_RP);
    chk("R2 bank1 ras pair", last_ras_pat, 4'b0011);
    chk("R8 miss data", d, init_val(8'hA7));
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    read_word(mk(0, 6, 2), d);
    chk("R8 reopen data", d, init_val(8'h62));
    repeat (40) @(negedge clk);
    chk("R9 idle close length", low_len, P_CLOSE);
    chk("R9 max row low", 32'(low_len <= P_RMAX), 1);
    chk("R9 row closed", dram_ras_n, 4'hF);
  endtask

  task automatic t_refresh;
    logic [31:0] d; int n = 0, cf, rc;
    read_word(mk(0, 1, 2), d);
    chk("R10 pre data", d, init_val(8'h12));
    ref_req = 1;
    while (!ref_gnt && n < 40) begin @(negedge clk); n++; end
    chk("R10 grant given", ref_gnt, 1);
    chk("R10 row closed", dram_ras_n, 4'hF);
    cf = cas_falls; rc = rsp_cnt;
    req_valid = 1; req_addr = mk(0, 1, 3); req_we = 0; req_be = 0;
    n = 0;
    repeat (10) begin @(negedge clk); if (acc) n++; end
    chk("R10 no accept while refresh", n, 0);
    chk("R10 no strobe while refresh", cas_falls, cf);
    chk("R10 pins quiet", quiet_bad, 0);
    ref_req = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!acc && n < 40);
    req_valid = 0;
    chk("R10 grant released", ref_gnt, 0);
    n = 0;
    while (rsp_cnt == rc && n < 40) begin @(negedge clk); n++; end
    chk("R10 post data", rsp_data, init_val(8'h13));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write_read;
    t_byte;
    t_miss;
    t_timeout;
    t_refresh;
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule